// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block keeps the interrupt enable bits of a real-time clock's control register and the event flags of its status register. It merges periodic, alarm and update-ended events into one active-low, open-drain interrupt request. Event generation happens outside the block and arrives here as single-cycle pulses. Dividers, alarm comparison and the update cycle are not part of the block. Square-wave rate selection is also outside the block, but the stored square-wave enable bit lives here.

A host reaches both registers through a one-bit select with write and read strobes. The control register is writable and reads back. The status register is read-only, and reading it acknowledges every pending flag. The pin is modelled as an output enable: while `irq_oe` is high, the pad pulls the line low. While it is low, the line floats.

Top module: `rtc_irq_ctl`

## Requirements
- R1: `irq_oe` is high exactly when the summary flag is set. The summary flag reads as bit 7 of the status register and equals (PF and PIE) or (AF and AIE) or (UF and UIE). An enabled event pulse therefore raises `irq_oe` one cycle later.
- R2: With `sel`=0 and `wr_en` high, the control register takes `wdata` at the clock edge and reads back on `rdata` with `sel`=0. Bit 6 is PIE, bit 5 is AIE, bit 4 is UIE and bit 3 is the square-wave enable, which also drives `sqw_en`. Bits 7 and 2..0 are plain storage.
- R3: With `sel`=1, `rdata` shows the status register: bit 7 summary flag, bit 6 PF, bit 5 AF, bit 4 UF. Bits 3..0 always read 0.
- R4: `evt_periodic`, `evt_alarm` and `evt_update` set PF, AF and UF at the next edge, whether or not the matching enable is set.
- R5: The summary flag follows enable changes. Writing an enable over a pending flag raises `irq_oe` after that write. Clearing the enable drops `irq_oe` after that write.
- R6: A read strobe with `sel`=1 sees the current status on `rdata` in that cycle. PF, AF and UF are all 0 after the edge.
- R7: An event pulse in the same cycle as a status read is kept. Its flag is set after the edge.
- R8: A write strobe with `sel`=1 leaves the status register unchanged.
- R9: While `rst_n` is low, PIE, AIE, UIE, the square-wave enable and all four status flags are 0, `irq_oe` is 0 and `rdata` is 0.
- R10: While `rst_n` is low, host writes and reads have no effect, and event pulses set no flag. Bits 7 and 2..0 of the control register keep the value they held before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Selected register contents |
| sqw_en | output | 1 | Stored square-wave enable |
| irq_oe | output | 1 | Interrupt pad pull-down enable |

## Verification
The block has no parameters, so the bench builds it at its fixed 8-bit register width with these bit positions. That makes every bit of both registers visible, so each cycle's comparison covers the enable, flag and plain-storage fields together. Within that one build, the bench reaches each source alone, several sources at once, and enables raised after and dropped before a pending flag. It also reaches a status read that collides with a new event, and a reset asserted over stored plain bits.

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sqw_en,
  output logic       irq_oe
);
  // en: {PIE, AIE, UIE, SQWE}; flags: {PF, AF, UF}
  logic [3:0] en;
  logic [3:0] misc;
  logic [2:0] flags;
  logic [2:0] evts;
  logic       wr_ctl, rd_stat, irqf;
  logic [7:0] ctl_r, stat_r;

  assign evts    = {evt_periodic, evt_alarm, evt_update};
  assign wr_ctl  = wr_en && !sel;
  assign rd_stat = rd_en && sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      en <= '0;
    else if (wr_ctl) en <= wdata[6:3];

  always_ff @(posedge clk)
    if (rst_n && wr_ctl) misc <= {wdata[7], wdata[2:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flags <= '0;
    else if (rd_stat) flags <= evts;
    else              flags <= flags | evts;

  assign irqf   = |(flags & en[3:1]);
  assign ctl_r  = {misc[3], en, misc[2:0]};
  assign stat_r = {irqf, flags, 4'b0000};
  assign rdata  = rst_n ? (sel ? stat_r : ctl_r) : 8'h00;
  assign sqw_en = en[0];
  assign irq_oe = irqf && rst_n;
endmodule

// File: rtl/rtc_irq_ctl_chk.sv
module rtc_irq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic       sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [3:0] en,
  input logic [2:0] flags,
  input logic       irq_oe
);
  logic any_evt;
  assign any_evt = evt_periodic || evt_alarm || evt_update;

  // R1
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_periodic && en[3] && !(wr_en && !sel)) |=> irq_oe);

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm |=> flags[1]);

  // R6
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel && !any_evt) |=> (flags == 3'b000 && !irq_oe));

  // R7
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel && evt_update) |=> flags[0]);

  // R8
  wr_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && !rd_en && !any_evt) |=> $stable(flags));

  // R9
  always @(posedge clk)
    if (rst_n === 1'b0)
      rst_rel_chk: assert (!irq_oe && en == 4'b0000 && flags == 3'b000);
endmodule

bind rtc_irq_ctl rtc_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
  .evt_update(evt_update), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .en(en), .flags(flags), .irq_oe(irq_oe)
);

// File: tb/sim_rtc_irq_ctl.sv
`timescale 1ns/1ps
module sim_rtc_irq_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ep = 0, ea = 0, eu = 0, sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic sqw_en, irq_oe;

  int n_cmp = 0, n_bad = 0;
  string tag = "R9";
  bit done = 0;

  // reference state
  bit [7:0] m_b = 0;
  bit [7:0] m_mask = 8'h78;
  bit m_pf = 0, m_af = 0, m_uf = 0;

  rtc_irq_ctl u0 (
    .clk(clk), .rst_n(rst_n), .evt_periodic(ep), .evt_alarm(ea), .evt_update(eu),
    .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .sqw_en(sqw_en), .irq_oe(irq_oe)
  );

  always #2.5 clk = ~clk;

  function automatic bit m_irqf();
    return (m_pf && m_b[6]) || (m_af && m_b[5]) || (m_uf && m_b[4]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_b[6:3] = 4'b0000;
      m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      if (rd_en && sel) begin
        m_pf = ep; m_af = ea; m_uf = eu;
      end else begin
        m_pf = m_pf | ep; m_af = m_af | ea; m_uf = m_uf | eu;
      end
      if (wr_en && !sel) begin
        m_b = wdata; m_mask = 8'hFF;
      end
    end
  end

  task automatic cmp(string t, logic [7:0] got, logic [7:0] exp, logic [7:0] mask);
    n_cmp++;
    if ((got & mask) !== (exp & mask)) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (mask %02h) at %0t", t, got, exp, mask, $time);
    end
  endtask

  // every clock: compare at negedge before new inputs
  always @(negedge clk) if (!done) begin
    logic [7:0] e_stat, e_rd, mk;
    e_stat = {m_irqf(), m_pf, m_af, m_uf, 4'b0000};
    e_rd = !rst_n ? 8'h00 : (sel ? e_stat : m_b);
    mk = (!rst_n || sel) ? 8'hFF : m_mask;
    cmp({tag, " rdata"}, rdata, e_rd, mk);
    cmp({tag, " irq_oe"}, {7'b0, irq_oe}, {7'b0, m_irqf() && rst_n}, 8'h01);
    cmp({tag, " sqw_en"}, {7'b0, sqw_en}, {7'b0, m_b[3]}, 8'h01);
  end

  task automatic cyc(bit p, bit a, bit u, bit s, bit w, bit r, logic [7:0] d);
    @(negedge clk); #0.1;
    ep = p; ea = a; eu = u; sel = s; wr_en = w; rd_en = r; wdata = d;
  endtask

  task automatic idle(bit s, int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, s, 0, 0, 8'h00);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R9 / R10: access and events while in reset
    tag = "R9";
    cyc(1, 1, 1, 0, 1, 0, 8'hFF);
    cyc(0, 0, 0, 1, 0, 1, 8'h00);
    idle(1, 2);
    tag = "R10";
    cyc(1, 0, 0, 1, 1, 1, 8'hFF);
    idle(0, 1);
    @(negedge clk); #0.2 rst_n = 1'b1;
    // R2: write control, plain bits and enables read back
    tag = "R2";
    cyc(0, 0, 0, 0, 1, 0, 8'h85);
    idle(0, 2);
    cyc(0, 0, 0, 0, 1, 0, 8'h8F);
    idle(0, 2);
    cyc(0, 0, 0, 0, 1, 0, 8'h80);
    idle(0, 1);
    // R4 / R3: events with enables off
    tag = "R4";
    cyc(1, 0, 0, 1, 0, 0, 8'h00);
    cyc(0, 1, 0, 1, 0, 0, 8'h00);
    cyc(0, 0, 1, 1, 0, 0, 8'h00);
    tag = "R3";
    idle(1, 2);
    // R5: enable late, then disable
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 0, 8'h20);
    idle(1, 2);
    cyc(0, 0, 0, 0, 1, 0, 8'h00);
    idle(1, 2);
    cyc(0, 0, 0, 0, 1, 0, 8'h50);
    idle(1, 2);
    // R6: read acknowledges
    tag = "R6";
    cyc(0, 0, 0, 1, 0, 1, 8'h00);
    idle(1, 2);
    // R1: each source alone with its enable
    tag = "R1";
    cyc(0, 0, 0, 0, 1, 0, 8'h70);
    cyc(1, 0, 0, 1, 0, 0, 8'h00);
    idle(1, 1);
    cyc(0, 0, 0, 1, 0, 1, 8'h00);
    cyc(0, 1, 0, 1, 0, 0, 8'h00);
    idle(1, 1);
    cyc(0, 0, 0, 1, 0, 1, 8'h00);
    cyc(0, 0, 1, 1, 0, 0, 8'h00);
    idle(1, 1);
    cyc(0, 0, 0, 1, 0, 1, 8'h00);
    idle(1, 1);
    // R7: event colliding with read
    tag = "R7";
    cyc(1, 0, 0, 1, 0, 0, 8'h00);
    cyc(0, 1, 1, 1, 0, 1, 8'h00);
    idle(1, 2);
    cyc(0, 0, 0, 1, 0, 1, 8'h00);
    idle(1, 1);
    // R8: write to status ignored
    tag = "R8";
    cyc(0, 1, 0, 1, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 1, 0, 8'hFF);
    idle(1, 1);
    cyc(0, 0, 0, 1, 1, 0, 8'h00);
    idle(1, 1);
    // R10: reset over stored plain bits and pending irq
    tag = "R10";
    cyc(0, 0, 0, 0, 1, 0, 8'hFF);
    cyc(1, 1, 1, 1, 0, 0, 8'h00);
    idle(1, 1);
    @(negedge clk); #0.2 rst_n = 1'b0;
    idle(1, 2);
    cyc(0, 0, 0, 0, 1, 0, 8'h00);
    idle(0, 2);
    @(negedge clk); #0.2 rst_n = 1'b1;
    idle(0, 2);
    idle(1, 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule